// File: doc/BRIEF.md
# Chained Performance Counter Bank

This block is a bank of 32-bit event counters and one 64-bit cycle counter. It is programmed through a plain register port: one write strobe, a byte address, write data and a combinational read-data bus. Each event counter has its own event-type register. A counter counts the clock cycles in which the event line chosen by its type pulses. It can also be bumped by a software-increment write, or by the overflow of its even-numbered neighbour when the two are chained into one 64-bit count.

A control register holds three things: the global enable, a switch that moves the cycle counter's overflow point from 32 to 64 bits, and a read-only field giving the number of event counters. Writing the control register can also clear all event counters or the cycle counter. Every counter has a sticky overflow flag. The three per-counter masks (overflow, counter enable, interrupt enable) are combined into one level-sensitive interrupt, which is held low while the bank is globally disabled. Each mask register has a set address and a clear address.

Top module: `pmu_chain_bank`

## Requirements
- R1: After reset, every counter, event type and mask register reads 0, the interrupt is low, and the control register at byte 0x000 reads the number of event counters in bits 15:11, with all other bits 0.
- R2: A counter changes only when the global enable (control bit 0) is 1 and its own bit in the counter-enable register is 1. While the global enable is 0 no counter wraps.
- R3: Event counter i sits at byte 0x100+4i. Its 16-bit event type sits at byte 0x180+4i. The counter adds one at each clock edge where event line `ev_pulse[type]` is high. Types 0x0000 (software increment), 0x001E (chain) and any value at or above the number of event lines never count event lines.
- R4: When an event counter steps from 0xFFFFFFFF to 0, its bit in the overflow register is set at the same clock edge.
- R5: The cycle counter is at bytes 0x020 (low word) and 0x024 (high word). It counts every enabled clock through counter-enable bit 31, and sets overflow bit 31 at a 32-bit wrap of its low word. When control bit 6 is 1, it sets that bit only at a 64-bit wrap.
- R6: An even counter i with i+1 below the counter count chains into counter i+1. When counter i wraps, counter i+1 adds one at the same edge, provided counter i+1 is enabled and its type is 0x001E.
- R7: A write to byte 0x01C adds one to every valid, enabled event counter whose mask bit is 1 and whose type is 0x0000. Overflow and chaining from such a step follow R4 and R6. The register reads 0.
- R8: Counter enable, interrupt enable and overflow each have a set address and a clear address: 0x004/0x008, 0x00C/0x010 and 0x014/0x018. A 1 in the write data sets or clears that bit, and a 0 leaves it alone. Both addresses read the current value.
- R9: A control write with bit 1 set clears all event counters and leaves the cycle counter alone. A control write with bit 2 set clears the cycle counter.
- R10: A software write to a counter wins over an increment in the same cycle, and that increment is lost.
- R11: `irq` is the OR over all bits of overflow AND counter enable AND interrupt enable, taken while the global enable is 1. It is registered, so it shows the state one clock after that state changes.
- R12: Mask bits of counters that do not exist (indices from the counter count up to 30) cannot be set and read 0. Writes to absent counters or with a non-zero `reg_addr[1:0]` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_pulse | input | EVENT_LINES | Single-cycle event pulses, one line per event number |
| irq | output | 1 | Level-sensitive overflow interrupt |

## Verification
Counter values, overflow flags and mask registers take their new value at the clock edge that samples the write or the event pulse. Read data follows the address with no clock in between. The interrupt appears one edge after the state that causes it. The bench drives each stimulus in the low phase before an edge, steps its model at that edge, and compares read data and `irq` in the low phase before the next edge. A directed interrupt check therefore expects the old level in the first cycle after an overflow and the new level in the second.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int REG_AW  = 9;
  localparam int CYC_IDX = 31;

  localparam logic [15:0] EV_SWINC = 16'h0000;
  localparam logic [15:0] EV_CHAIN = 16'h001E;

  // word addresses (byte address >> 2)
  localparam logic [6:0] W_CTRL  = 7'h00;
  localparam logic [6:0] W_ENSET = 7'h01;
  localparam logic [6:0] W_ENCLR = 7'h02;
  localparam logic [6:0] W_IESET = 7'h03;
  localparam logic [6:0] W_IECLR = 7'h04;
  localparam logic [6:0] W_OVSET = 7'h05;
  localparam logic [6:0] W_OVCLR = 7'h06;
  localparam logic [6:0] W_SWINC = 7'h07;
  localparam logic [6:0] W_CYCLO = 7'h08;
  localparam logic [6:0] W_CYCHI = 7'h09;
  localparam logic [1:0] W_CTR_GRP = 2'b10;  // 0x40..0x5F
  localparam logic [1:0] W_TYP_GRP = 2'b11;  // 0x60..0x7F

  // control bits
  localparam int CB_EN = 0;
  localparam int CB_P  = 1;
  localparam int CB_C  = 2;
  localparam int CB_LC = 6;
  localparam int CB_N  = 11;

  // lanes that exist: low n event counters plus the cycle lane
  function automatic logic [31:0] valid_mask(input int n);
    logic [31:0] m;
    m = '0;
    for (int j = 0; j < CYC_IDX; j++) if (j < n) m[j] = 1'b1;
    m[CYC_IDX] = 1'b1;
    return m;
  endfunction

  // even lane whose odd partner exists and is an event counter
  function automatic logic chain_source(input int i, input int n);
    return (i % 2 == 0) && (i + 1 < CYC_IDX) && (i + 1 < n);
  endfunction

  function automatic logic wraps32(input logic [31:0] v);
    return &v;
  endfunction

  function automatic logic cyc_wraps(input logic [63:0] v, input logic long_ovf);
    return long_ovf ? (&v) : (&v[31:0]);
  endfunction

  function automatic logic irq_level(input logic en, input logic [31:0] ovf,
                                     input logic [31:0] cten, input logic [31:0] ie);
    return en && (|(ovf & cten & ie));
  endfunction

endpackage

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr
  import pmu_pkg::*;
#(
  parameter int LINES = 64,
  parameter int LW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic             typ_wr,
  input  logic [31:0]      wdata,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic [LINES-1:0] ev_lines,
  input  logic             sw_req,
  input  logic             chain_req,
  output logic [31:0]      count,
  output logic [15:0]      evtype,
  output logic             wrap
);

  logic is_sw, is_chain, in_range, hw_hit, step;

  assign is_sw    = (evtype == EV_SWINC);
  assign is_chain = (evtype == EV_CHAIN);
  assign in_range = (evtype[15:LW] == '0);
  assign hw_hit   = !is_sw && !is_chain && in_range && ev_lines[evtype[LW-1:0]];
  assign step     = cnt_en && !cnt_wr && !clr &&
                    (hw_hit || (sw_req && is_sw) || (chain_req && is_chain));
  assign wrap     = step && wraps32(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      evtype <= '0;
    end else begin
      if (cnt_wr)     count <= wdata;
      else if (clr)   count <= '0;
      else if (step)  count <= count + 32'd1;
      if (typ_wr) evtype <= wdata[15:0];
    end
  end

endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr
  import pmu_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [31:0]   wdata,
  input  logic          clr,
  input  logic          cnt_en,
  input  logic          long_ovf,
  output logic [CW-1:0] count,
  output logic          wrap
);

  logic step;

  assign step = cnt_en && !wr_lo && !wr_hi && !clr;
  assign wrap = step && cyc_wraps(count, long_ovf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (wr_lo)  count[31:0]    <= wdata;
    else if (wr_hi)  count[CW-1:32] <= wdata;
    else if (clr)    count <= '0;
    else if (step)   count <= count + 64'd1;
  end

endmodule

// File: rtl/pmu_irq.sv
module pmu_irq
  import pmu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        glob_en,
  input  logic [31:0] ovf,
  input  logic [31:0] cten,
  input  logic [31:0] inten,
  output logic        irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_level(glob_en, ovf, cten, inten);
  end

endmodule

// File: rtl/pmu_chain_bank.sv
module pmu_chain_bank
  import pmu_pkg::*;
#(
  parameter int N_CTR       = 6,
  parameter int EVENT_LINES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [REG_AW-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [EVENT_LINES-1:0] ev_pulse,
  output logic                   irq
);

  localparam logic [31:0] VMASK = valid_mask(N_CTR);
  localparam logic [31:0] EMASK = VMASK & ~(32'd1 << CYC_IDX);
  localparam int          LW    = $clog2(EVENT_LINES);

  logic [6:0]  wa;
  logic        wr_ok;
  logic        wr_ctrl, wr_enset, wr_enclr, wr_ieset, wr_ieclr;
  logic        wr_ovset, wr_ovclr, wr_swinc, wr_cyclo, wr_cychi;
  logic        p_clr, c_clr;
  logic        en_q, lc_q;
  logic [31:0] cten_q, inten_q, ovf_q;
  logic [31:0] wrap_all, chain_vec, ctr_wr_vec, typ_wr_vec, sw_vec, cnt_en_vec;
  logic [31:0] cnt_all [32];
  logic [15:0] typ_all [32];
  logic [63:0] cyc_cnt;

  // ---------------- decode ----------------
  assign wa       = reg_addr[REG_AW-1:2];
  assign wr_ok    = reg_wr && (reg_addr[1:0] == 2'b00);
  assign wr_ctrl  = wr_ok && (wa == W_CTRL);
  assign wr_enset = wr_ok && (wa == W_ENSET);
  assign wr_enclr = wr_ok && (wa == W_ENCLR);
  assign wr_ieset = wr_ok && (wa == W_IESET);
  assign wr_ieclr = wr_ok && (wa == W_IECLR);
  assign wr_ovset = wr_ok && (wa == W_OVSET);
  assign wr_ovclr = wr_ok && (wa == W_OVCLR);
  assign wr_swinc = wr_ok && (wa == W_SWINC);
  assign wr_cyclo = wr_ok && (wa == W_CYCLO);
  assign wr_cychi = wr_ok && (wa == W_CYCHI);
  assign p_clr    = wr_ctrl && reg_wdata[CB_P];
  assign c_clr    = wr_ctrl && reg_wdata[CB_C];

  assign sw_vec     = wr_swinc ? (reg_wdata & EMASK) : '0;
  assign cnt_en_vec = en_q ? cten_q : '0;

  // ---------------- counter lanes ----------------
  for (genvar i = 0; i < CYC_IDX; i++) begin : g_lane
    assign ctr_wr_vec[i] = wr_ok && (wa[6:5] == W_CTR_GRP) && (wa[4:0] == 5'(i)) && (i < N_CTR);
    assign typ_wr_vec[i] = wr_ok && (wa[6:5] == W_TYP_GRP) && (wa[4:0] == 5'(i)) && (i < N_CTR);

    if (i < N_CTR) begin : g_ctr
      pmu_evt_ctr #(.LINES(EVENT_LINES), .LW(LW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (ctr_wr_vec[i]),
        .typ_wr    (typ_wr_vec[i]),
        .wdata     (reg_wdata),
        .clr       (p_clr),
        .cnt_en    (cnt_en_vec[i]),
        .ev_lines  (ev_pulse),
        .sw_req    (sw_vec[i]),
        .chain_req (chain_vec[i]),
        .count     (cnt_all[i]),
        .evtype    (typ_all[i]),
        .wrap      (wrap_all[i])
      );
    end else begin : g_absent
      assign cnt_all[i]  = '0;
      assign typ_all[i]  = '0;
      assign wrap_all[i] = 1'b0;
    end

    if ((i % 2 == 1) && chain_source(i - 1, N_CTR)) begin : g_chain
      assign chain_vec[i] = wrap_all[i-1];
    end else begin : g_nochain
      assign chain_vec[i] = 1'b0;
    end
  end

  assign ctr_wr_vec[CYC_IDX] = wr_cyclo || wr_cychi;
  assign typ_wr_vec[CYC_IDX] = 1'b0;
  assign chain_vec[CYC_IDX]  = 1'b0;
  assign cnt_all[CYC_IDX]    = '0;
  assign typ_all[CYC_IDX]    = '0;

  pmu_cyc_ctr #(.CW(64)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_cyclo),
    .wr_hi    (wr_cychi),
    .wdata    (reg_wdata),
    .clr      (c_clr),
    .cnt_en   (cnt_en_vec[CYC_IDX]),
    .long_ovf (lc_q),
    .count    (cyc_cnt),
    .wrap     (wrap_all[CYC_IDX])
  );

  // ---------------- control and mask registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      lc_q    <= 1'b0;
      cten_q  <= '0;
      inten_q <= '0;
      ovf_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q <= reg_wdata[CB_EN];
        lc_q <= reg_wdata[CB_LC];
      end
      if (wr_enset) cten_q  <= cten_q  | (reg_wdata & VMASK);
      if (wr_enclr) cten_q  <= cten_q  & ~reg_wdata;
      if (wr_ieset) inten_q <= inten_q | (reg_wdata & VMASK);
      if (wr_ieclr) inten_q <= inten_q & ~reg_wdata;
      ovf_q <= ((ovf_q & ~(wr_ovclr ? reg_wdata : 32'd0))
               | (wr_ovset ? reg_wdata : 32'd0) | wrap_all) & VMASK;
    end
  end

  pmu_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .glob_en (en_q),
    .ovf     (ovf_q),
    .cten    (cten_q),
    .inten   (inten_q),
    .irq     (irq)
  );

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    case (wa)
      W_CTRL: begin
        reg_rdata[CB_EN]        = en_q;
        reg_rdata[CB_LC]        = lc_q;
        reg_rdata[CB_N+4:CB_N]  = 5'(N_CTR);
      end
      W_ENSET, W_ENCLR: reg_rdata = cten_q;
      W_IESET, W_IECLR: reg_rdata = inten_q;
      W_OVSET, W_OVCLR: reg_rdata = ovf_q;
      W_CYCLO:          reg_rdata = cyc_cnt[31:0];
      W_CYCHI:          reg_rdata = cyc_cnt[63:32];
      default: begin
        if (wa[6:5] == W_CTR_GRP)      reg_rdata = cnt_all[wa[4:0]];
        else if (wa[6:5] == W_TYP_GRP) reg_rdata = {16'h0000, typ_all[wa[4:0]]};
      end
    endcase
  end

endmodule

// File: rtl/pmu_chain_bank_chk.sv
module pmu_chain_bank_chk
  import pmu_pkg::*;
#(
  parameter int N_CTR = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        glob_en,
  input logic [31:0] ovf,
  input logic [31:0] cten,
  input logic [31:0] inten,
  input logic [31:0] wrap_all,
  input logic [31:0] chain_vec,
  input logic [31:0] ctr_wr_vec
);

  localparam logic [31:0] VM = valid_mask(N_CTR);

  // R4 / R5: a wrap leaves its overflow flag set after the edge
  p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_all) |=> ((ovf & $past(wrap_all)) == $past(wrap_all)));

  // R2: nothing wraps while globally disabled
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> (wrap_all == '0));

  // R10: a lane written this cycle does not step
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctr_wr_vec & wrap_all) == '0));

  // R6: a chained step only reaches an odd lane whose lower neighbour wraps
  p_chain_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|chain_vec) |-> ((chain_vec & ~{wrap_all[30:0], 1'b0}) == '0));

  // R11: interrupt follows the gated masks one edge later
  p_irq_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(glob_en && (|(ovf & cten & inten)))));

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !irq);

  // R12: absent lanes never hold a mask bit
  p_mask_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (((cten | inten | ovf) & ~VM) == '0));

endmodule

bind pmu_chain_bank pmu_chain_bank_chk #(.N_CTR(N_CTR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .glob_en    (en_q),
  .ovf        (ovf_q),
  .cten       (cten_q),
  .inten      (inten_q),
  .wrap_all   (wrap_all),
  .chain_vec  (chain_vec),
  .ctr_wr_vec (ctr_wr_vec)
);

// File: tb/test_pmu_chain_bank.sv
`timescale 1ns/1ps
module test_pmu_chain_bank;

  localparam int N      = 6;
  localparam int LINES  = 64;
  localparam int MAXCYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [LINES-1:0] ev_pulse = '0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] last_rd;
  logic        last_irq;

  // reference state
  logic        m_en, m_lc, m_irq;
  logic [31:0] m_cten, m_ie, m_ovf;
  logic [31:0] m_cnt [0:30];
  logic [15:0] m_typ [0:30];
  logic [63:0] m_cyc;

  always #5 clk = ~clk;

  pmu_chain_bank #(.N_CTR(N), .EVENT_LINES(LINES)) i_pmu_chain_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pulse(ev_pulse), .irq(irq)
  );

  function automatic logic [31:0] vmask();
    logic [31:0] m;
    m = 32'h8000_0000;
    for (int j = 0; j < N; j++) m[j] = 1'b1;
    return m;
  endfunction

  function automatic string tag_of(input logic [8:0] a);
    logic [6:0] w;
    w = a[8:2];
    if (w == 7'h00) return "R1";
    if (w >= 7'h01 && w <= 7'h06) return "R8";
    if (w == 7'h07) return "R7";
    if (w == 7'h08 || w == 7'h09) return "R5";
    if (w >= 7'h40 && w < 7'h40 + 7'(N)) return "R4";
    if (w >= 7'h60 && w < 7'h60 + 7'(N)) return "R3";
    return "R12";
  endfunction

  function automatic logic [31:0] mread(input logic [8:0] a);
    logic [6:0] w;
    w = a[8:2];
    case (w)
      7'h00: return {16'h0, 5'(N), 4'h0, m_lc, 5'h0, m_en};
      7'h01, 7'h02: return m_cten;
      7'h03, 7'h04: return m_ie;
      7'h05, 7'h06: return m_ovf;
      7'h08: return m_cyc[31:0];
      7'h09: return m_cyc[63:32];
      default: begin
        if (w >= 7'h40 && w < 7'h40 + 7'(N)) return m_cnt[w - 7'h40];
        if (w >= 7'h60 && w < 7'h60 + 7'(N)) return {16'h0, m_typ[w - 7'h60]};
        return 32'h0;
      end
    endcase
  endfunction

  function automatic void model_reset();
    m_en = 0; m_lc = 0; m_irq = 0; m_cten = 0; m_ie = 0; m_ovf = 0; m_cyc = 0;
    for (int i = 0; i < 31; i++) begin m_cnt[i] = 0; m_typ[i] = 0; end
  endfunction

  // one clock edge of the reference, written from the requirements
  function automatic void model_step(input logic wr, input logic [8:0] a,
                                     input logic [31:0] d, input logic [63:0] ev);
    logic [6:0]  w;
    logic        ok, irq_n, hw, sw, ch, clrp;
    logic [31:0] wrapv, vm;
    logic [15:0] t;
    w = a[8:2];
    ok = wr && (a[1:0] == 2'b00);
    vm = vmask();
    irq_n = m_en && ((m_ovf & m_cten & m_ie) != 0);
    wrapv = 0;
    clrp = ok && w == 7'h00 && d[1];
    for (int i = 0; i < N; i++) begin
      t  = m_typ[i];
      hw = (t != 16'h0 && t != 16'h1E && t < LINES) ? ev[t[5:0]] : 1'b0;
      sw = ok && w == 7'h07 && d[i] && t == 16'h0;
      ch = (i % 2 == 1) && wrapv[i-1] && t == 16'h1E;
      if (ok && w == 7'h40 + 7'(i)) m_cnt[i] = d;
      else if (clrp) m_cnt[i] = 0;
      else if (m_en && m_cten[i] && (hw || sw || ch)) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) wrapv[i] = 1'b1;
        m_cnt[i] = m_cnt[i] + 1;
      end
    end
    if (ok && w == 7'h08) m_cyc[31:0] = d;
    else if (ok && w == 7'h09) m_cyc[63:32] = d;
    else if (ok && w == 7'h00 && d[2]) m_cyc = 0;
    else if (m_en && m_cten[31]) begin
      if (m_lc ? (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) : (m_cyc[31:0] == 32'hFFFF_FFFF))
        wrapv[31] = 1'b1;
      m_cyc = m_cyc + 1;
    end
    for (int i = 0; i < N; i++)
      if (ok && w == 7'h60 + 7'(i)) m_typ[i] = d[15:0];
    if (ok && w == 7'h01) m_cten = m_cten | (d & vm);
    if (ok && w == 7'h02) m_cten = m_cten & ~d;
    if (ok && w == 7'h03) m_ie = m_ie | (d & vm);
    if (ok && w == 7'h04) m_ie = m_ie & ~d;
    m_ovf = ((m_ovf & ~((ok && w == 7'h06) ? d : 32'h0))
             | ((ok && w == 7'h05) ? d : 32'h0) | wrapv) & vm;
    if (ok && w == 7'h00) begin m_en = d[0]; m_lc = d[6]; end
    m_irq = irq_n;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic wr, input logic [8:0] a, input logic [31:0] d,
                      input logic [63:0] ev);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; ev_pulse = ev;
    #1;
    last_rd = reg_rdata;
    last_irq = irq;
    if (!wr) check(tag_of(a), {32'h0, last_rd}, {32'h0, mread(a)});
    check("R11", {63'h0, last_irq}, {63'h0, m_irq});
    @(posedge clk);
    #1;
    model_step(wr, a, d, ev);
  endtask

  task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
    tick(1'b1, a, d, 64'h0);
  endtask

  task automatic rd_chk(input logic [8:0] a, input logic [31:0] exp,
                        input logic [31:0] mask, input string tag);
    tick(1'b0, a, 32'h0, 64'h0);
    check(tag, {32'h0, last_rd & mask}, {32'h0, exp});
  endtask

  function automatic logic [8:0] rand_addr();
    int r;
    r = int'($urandom % 24);
    if (r < 10) return 9'(r * 4);
    if (r < 17) return 9'h100 + 9'((r - 10) * 4);
    return 9'h180 + 9'((r - 17) * 4);
  endfunction

  initial begin
    #(MAXCYC * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [8:0]  a;
    logic [31:0] d;
    logic [63:0] ev;
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    rd_chk(9'h000, 32'h0000_3000, 32'hFFFF_FFFF, "R1");
    rd_chk(9'h100, 32'h0, 32'hFFFF_FFFF, "R1");
    rd_chk(9'h014, 32'h0, 32'hFFFF_FFFF, "R1");

    // R12: only existing lanes take mask bits; absent counter ignored
    wr_reg(9'h004, 32'hFFFF_FFFF);
    rd_chk(9'h004, 32'h8000_003F, 32'hFFFF_FFFF, "R12");
    rd_chk(9'h008, 32'h8000_003F, 32'hFFFF_FFFF, "R8");
    wr_reg(9'h11C, 32'h1234);
    rd_chk(9'h11C, 32'h0, 32'hFFFF_FFFF, "R12");
    wr_reg(9'h101, 32'h99);   // misaligned: ignored
    rd_chk(9'h100, 32'h0, 32'hFFFF_FFFF, "R12");

    // R2 / R3: gating and type matching
    wr_reg(9'h180, 32'h3);
    wr_reg(9'h184, 32'h3);
    wr_reg(9'h188, 32'h43);
    wr_reg(9'h008, 32'h2);
    tick(1'b0, 9'h100, 32'h0, 64'h9);
    rd_chk(9'h100, 32'h0, 32'hFFFF_FFFF, "R2");
    wr_reg(9'h000, 32'h1);
    tick(1'b0, 9'h100, 32'h0, 64'h9);
    tick(1'b0, 9'h100, 32'h0, 64'h9);
    rd_chk(9'h100, 32'h2, 32'hFFFF_FFFF, "R3");
    rd_chk(9'h104, 32'h0, 32'hFFFF_FFFF, "R2");
    rd_chk(9'h108, 32'h0, 32'hFFFF_FFFF, "R3");
    rd_chk(9'h10C, 32'h0, 32'hFFFF_FFFF, "R3");

    // R4 / R11: wrap, flag, interrupt one edge later, gate
    wr_reg(9'h100, 32'hFFFF_FFFF);
    wr_reg(9'h00C, 32'h1);
    tick(1'b0, 9'h014, 32'h0, 64'h8);
    rd_chk(9'h014, 32'h1, 32'h1, "R4");
    check("R11", {63'h0, last_irq}, 64'h0);
    rd_chk(9'h100, 32'h0, 32'hFFFF_FFFF, "R4");
    check("R11", {63'h0, last_irq}, 64'h1);
    wr_reg(9'h000, 32'h0);
    rd_chk(9'h014, 32'h1, 32'h1, "R11");
    check("R11", {63'h0, last_irq}, 64'h1);
    rd_chk(9'h014, 32'h1, 32'h1, "R11");
    check("R11", {63'h0, last_irq}, 64'h0);
    wr_reg(9'h000, 32'h1);
    wr_reg(9'h018, 32'h1);

    // R6: chaining
    wr_reg(9'h184, 32'h1E);
    wr_reg(9'h004, 32'h2);
    wr_reg(9'h104, 32'h5);
    wr_reg(9'h100, 32'hFFFF_FFFF);
    tick(1'b0, 9'h100, 32'h0, 64'h8);
    rd_chk(9'h104, 32'h6, 32'hFFFF_FFFF, "R6");
    rd_chk(9'h100, 32'h0, 32'hFFFF_FFFF, "R6");
    rd_chk(9'h014, 32'h0, 32'h2, "R6");
    wr_reg(9'h18C, 32'h1E);
    wr_reg(9'h188, 32'h4);
    wr_reg(9'h108, 32'hFFFF_FFFF);
    wr_reg(9'h008, 32'h8);
    tick(1'b0, 9'h100, 32'h0, 64'h10);
    rd_chk(9'h10C, 32'h0, 32'hFFFF_FFFF, "R6");

    // R7: software increment
    wr_reg(9'h008, 32'h20);
    wr_reg(9'h01C, 32'h31);
    rd_chk(9'h110, 32'h1, 32'hFFFF_FFFF, "R7");
    rd_chk(9'h114, 32'h0, 32'hFFFF_FFFF, "R7");
    rd_chk(9'h01C, 32'h0, 32'hFFFF_FFFF, "R7");

    // R5: cycle counter, 32-bit then 64-bit overflow point
    wr_reg(9'h024, 32'h0);
    wr_reg(9'h020, 32'hFFFF_FFFE);
    rd_chk(9'h020, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R5");
    rd_chk(9'h014, 32'h0, 32'h8000_0000, "R5");
    rd_chk(9'h024, 32'h1, 32'hFFFF_FFFF, "R5");
    rd_chk(9'h014, 32'h8000_0000, 32'h8000_0000, "R5");
    wr_reg(9'h018, 32'h8000_0000);
    wr_reg(9'h000, 32'h41);
    wr_reg(9'h024, 32'h0);
    wr_reg(9'h020, 32'hFFFF_FFFE);
    tick(1'b0, 9'h020, 32'h0, 64'h0);
    tick(1'b0, 9'h020, 32'h0, 64'h0);
    rd_chk(9'h014, 32'h0, 32'h8000_0000, "R5");
    wr_reg(9'h024, 32'hFFFF_FFFF);
    wr_reg(9'h020, 32'hFFFF_FFFE);
    tick(1'b0, 9'h020, 32'h0, 64'h0);
    tick(1'b0, 9'h020, 32'h0, 64'h0);
    rd_chk(9'h014, 32'h8000_0000, 32'h8000_0000, "R5");
    rd_chk(9'h024, 32'h0, 32'hFFFF_FFFF, "R5");
    wr_reg(9'h000, 32'h1);

    // R9: event clear and cycle clear
    wr_reg(9'h100, 32'h77);
    wr_reg(9'h000, 32'h3);
    rd_chk(9'h100, 32'h0, 32'hFFFF_FFFF, "R9");
    rd_chk(9'h104, 32'h0, 32'hFFFF_FFFF, "R9");
    wr_reg(9'h000, 32'h5);
    rd_chk(9'h020, 32'h0, 32'hFFFF_FFFF, "R9");

    // R10: write beats increment
    tick(1'b1, 9'h100, 32'h55, 64'h8);
    rd_chk(9'h100, 32'h55, 32'hFFFF_FFFF, "R10");

    // R8: set/clear aliases
    wr_reg(9'h018, 32'hFFFF_FFFF);
    wr_reg(9'h014, 32'h5);
    rd_chk(9'h014, 32'h5, 32'hFFFF_FFFF, "R8");
    rd_chk(9'h018, 32'h5, 32'hFFFF_FFFF, "R8");
    wr_reg(9'h018, 32'h1);
    rd_chk(9'h014, 32'h4, 32'hFFFF_FFFF, "R8");
    wr_reg(9'h004, 32'h0);
    rd_chk(9'h004, 32'h8000_0017, 32'hFFFF_FFFF, "R8");

    // constrained random phase, every read and irq compared to the model
    for (int k = 0; k < 6000; k++) begin
      ev = 64'h0;
      if ($urandom % 2 == 0) ev[$urandom % 8] = 1'b1;
      if ($urandom % 4 == 0) ev[$urandom % 8] = 1'b1;
      if ($urandom % 100 < 30) begin
        a = rand_addr();
        d = $urandom;
        if (a == 9'h000) d = {25'h0, d[6], 2'b00, (d[3:1] == 3'b000) ? 2'b11 : 2'b00, ($urandom % 8 != 0)};
        else if (a >= 9'h100 && a < 9'h180) d = ($urandom % 2) ? (32'hFFFF_FFF0 | ($urandom % 16)) : d;
        else if (a == 9'h020) d = ($urandom % 2) ? (32'hFFFF_FFF0 | ($urandom % 16)) : d;
        else if (a >= 9'h180) begin
          case ($urandom % 4)
            0: d = 32'h0;
            1: d = 32'h1E;
            2: d = $urandom % 8;
            default: d = 32'h100 | ($urandom % 4);
          endcase
        end
        if ($urandom % 50 == 0) a = a | 9'h2;
        tick(1'b1, a, d, ev);
      end else begin
        tick(1'b0, rand_addr(), 32'h0, ev);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule